// File: doc/BRIEF.md
# Time-Slot Interchange Switch Core

This block is a memory-based time and space switch for synchronous TDM byte streams. Every clock is one time slot. In each slot it takes one byte from each of several input highways and stores it by highway and slot position. It also produces one byte on a single output stream. A programmable connection table says, for each output slot, which input highway and which input slot supply that output byte. Bytes can therefore be reordered inside a frame (time) and moved between highways (space).

The data store has three banks. The active bank advances at every frame boundary. A frame boundary is either the last slot of a frame or an external sync pulse. Each connection picks one of two latency modes. Low-latency mode reads the newest copy of the source byte. Frame-integrity mode always reads the last completed frame, so bonded multi-slot channels leave together. Each connection also carries a 4-bit table-select code and a test-insert flag. These travel beside the data byte for a later stage to use.

A host writes connection entries through a simple register port at any time. The writes go to a shadow copy. The whole shadow is applied at the next frame boundary, so an output frame never mixes old and new entries.

Top module: `tsi_switch_core`

## Requirements
- R1: While `rst` is high and in the first two cycles after it falls, `out_data` is 0xFF and `out_tbl` and `out_test` are 0. `host_rdata` is 0 after reset, and every connection entry starts out unconnected.
- R2: A slot counter starts at 0 after reset, advances by one per clock and wraps after slot NUM_SLOTS-1. The input bytes present while the counter is s are stored as slot s of each highway. The result for output slot o is presented on the outputs two clocks after the cycle in which the counter equals o.
- R3: A connection with the frame-integrity bit cleared (low latency) works on source slot s and output slot o. If s < o, it outputs the byte written in the current frame. If s >= o, it outputs the byte written in the previous frame.
- R4: A connection with the frame-integrity bit set always outputs the byte from the most recently completed frame, whatever the relation between s and o.
- R5: An output slot whose entry has the valid bit cleared outputs 0xFF, with `out_tbl` = 0 and `out_test` = 0.
- R6: For a valid entry, `out_tbl` and `out_test` carry the entry's table-select field and test-insert flag, aligned with the data byte.
- R7: Entry layout, LSB first: source slot (SLOT_W bits), source highway (HWY_W bits), table select (4 bits), test-insert (1 bit), frame-integrity (1 bit), valid (1 bit). `host_we` writes `host_wdata` into the shadow entry at `host_addr`. `host_rdata` returns the shadow entry at `host_addr` one clock later, as it stood before any write in that same cycle.
- R8: An entry written in any cycle of a frame, including that frame's last slot, first steers the outputs of the next frame. The current frame keeps using the old entries.
- R9: A high `fsync` ends the frame early. The next cycle is slot 0, the data-store bank advances and pending entries are applied. Slots not rewritten in a short frame keep the bytes stored in that bank three frames earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one time slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | Forces a frame boundary at the end of this cycle |
| in_data | input | NUM_HWY*DATA_W | One byte per input highway; highway h at bits h*DATA_W upward |
| host_we | input | 1 | Host write strobe for the connection table |
| host_addr | input | SLOT_W | Output slot index of the entry to access |
| host_wdata | input | ENT_W | Entry to write |
| host_rdata | output | ENT_W | Shadow entry at the previous cycle's address |
| out_data | output | DATA_W | Switched output byte |
| out_tbl | output | 4 | Table-select code of the connection for this byte |
| out_test | output | 1 | Test-insert flag of the connection for this byte |

## Verification
The bench builds the core with four highways and eight slots per frame. With frames this short, all three banks rotate many times in a hundred cycles, and stale bytes left by an early sync pulse can be observed. Four highways use every code of the 2-bit highway field. The connection table places source slots below, equal to and just under the output slot, so both sides of the low-latency cut-off and the minimum-delay case are covered. A reference model kept inside the bench predicts every output byte and every host read-back value.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int          NUM_BANKS = 3;
  localparam int          BANK_W    = 2;

  function automatic logic [BANK_W-1:0] bank_next(input logic [BANK_W-1:0] b);
    return (b == BANK_W'(NUM_BANKS - 1)) ? '0 : b + 1'b1;
  endfunction

  function automatic logic [BANK_W-1:0] bank_prev(input logic [BANK_W-1:0] b);
    return (b == '0) ? BANK_W'(NUM_BANKS - 1) : b - 1'b1;
  endfunction
endpackage

// File: rtl/tsi_frame_timer.sv
module tsi_frame_timer
  import tsi_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fsync,
  output logic [SLOT_W-1:0] slot_cnt,
  output logic [BANK_W-1:0] wr_bank,
  output logic              boundary
);
  assign boundary = fsync || (slot_cnt == SLOT_W'(NUM_SLOTS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_cnt <= '0;
      wr_bank  <= '0;
    end else if (boundary) begin
      slot_cnt <= '0;
      wr_bank  <= bank_next(wr_bank);
    end else begin
      slot_cnt <= slot_cnt + 1'b1;
    end
  end

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> slot_cnt == $past(slot_cnt) + 1'b1); // R2
  AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (rst)
    boundary |=> slot_cnt == '0); // R9
  AST_BANK_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    boundary |=> wr_bank != $past(wr_bank)); // R9
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> $stable(wr_bank)); // R2
endmodule

// File: rtl/tsi_conn_store.sv
module tsi_conn_store #(
  parameter int NUM_SLOTS = 32,
  parameter int ENT_W     = 14,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boundary,
  input  logic              host_we,
  input  logic [SLOT_W-1:0] host_addr,
  input  logic [ENT_W-1:0]  host_wdata,
  output logic [ENT_W-1:0]  host_rdata,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [ENT_W-1:0]  rd_entry
);
  logic [NUM_SLOTS-1:0][ENT_W-1:0] shadow;
  logic [NUM_SLOTS-1:0][ENT_W-1:0] active;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow     <= '0;
      active     <= '0;
      host_rdata <= '0;
    end else begin
      host_rdata <= shadow[host_addr];
      if (host_we) shadow[host_addr] <= host_wdata;
      if (boundary) begin
        for (int i = 0; i < NUM_SLOTS; i++)
          active[i] <= (host_we && host_addr == SLOT_W'(i)) ? host_wdata : shadow[i];
      end
    end
  end

  assign rd_entry = active[rd_slot];

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> $stable(active)); // R8
  AST_SHADOW_WRITE: assert property (@(posedge clk) disable iff (rst)
    host_we |=> shadow[$past(host_addr)] == $past(host_wdata)); // R7
endmodule

// File: rtl/tsi_data_store.sv
module tsi_data_store
  import tsi_pkg::*;
#(
  parameter int NUM_HWY   = 4,
  parameter int NUM_SLOTS = 32,
  parameter int DATA_W    = 8,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int DEPTH  = NUM_BANKS * NUM_SLOTS,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic [BANK_W-1:0]         wr_bank,
  input  logic [SLOT_W-1:0]         wr_slot,
  input  logic [NUM_HWY*DATA_W-1:0] wr_data,
  input  logic [BANK_W-1:0]         rd_bank,
  input  logic [SLOT_W-1:0]         rd_slot,
  output logic [NUM_HWY*DATA_W-1:0] rd_data
);
  logic [ADDR_W-1:0] waddr, raddr;

  assign waddr = ADDR_W'(wr_bank) * ADDR_W'(NUM_SLOTS) + ADDR_W'(wr_slot);
  assign raddr = ADDR_W'(rd_bank) * ADDR_W'(NUM_SLOTS) + ADDR_W'(rd_slot);

  for (genvar h = 0; h < NUM_HWY; h++) begin : g_hwy
    logic [DATA_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      mem[waddr] <= wr_data[h*DATA_W +: DATA_W];
      rd_data[h*DATA_W +: DATA_W] <= mem[raddr];
    end
  end
endmodule

// File: rtl/tsi_switch_core.sv
module tsi_switch_core
  import tsi_pkg::*;
#(
  parameter int NUM_HWY   = 4,
  parameter int NUM_SLOTS = 32,
  parameter int DATA_W    = 8,
  localparam int TBL_W  = 4,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int HWY_W  = $clog2(NUM_HWY),
  localparam int ENT_W  = SLOT_W + HWY_W + TBL_W + 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      fsync,
  input  logic [NUM_HWY*DATA_W-1:0] in_data,
  input  logic                      host_we,
  input  logic [SLOT_W-1:0]         host_addr,
  input  logic [ENT_W-1:0]          host_wdata,
  output logic [ENT_W-1:0]          host_rdata,
  output logic [DATA_W-1:0]         out_data,
  output logic [TBL_W-1:0]          out_tbl,
  output logic                      out_test
);
  localparam int HWY_LSB = SLOT_W;
  localparam int TBL_LSB = SLOT_W + HWY_W;
  localparam int TST_BIT = TBL_LSB + TBL_W;
  localparam int FI_BIT  = TST_BIT + 1;
  localparam int VLD_BIT = TST_BIT + 2;

  logic [SLOT_W-1:0]         slot_cnt;
  logic [BANK_W-1:0]         wr_bank, rd_bank;
  logic                      boundary;
  logic [ENT_W-1:0]          ent;
  logic [NUM_HWY*DATA_W-1:0] rd_data;

  tsi_frame_timer #(.NUM_SLOTS(NUM_SLOTS)) u_timer (
    .clk(clk), .rst(rst), .fsync(fsync),
    .slot_cnt(slot_cnt), .wr_bank(wr_bank), .boundary(boundary)
  );

  tsi_conn_store #(.NUM_SLOTS(NUM_SLOTS), .ENT_W(ENT_W)) u_conn (
    .clk(clk), .rst(rst), .boundary(boundary),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .rd_slot(slot_cnt), .rd_entry(ent)
  );

  logic              ent_valid, ent_fi;
  logic [SLOT_W-1:0] ent_slot;
  logic [HWY_W-1:0]  ent_hwy;

  assign ent_valid = ent[VLD_BIT];
  assign ent_fi    = ent[FI_BIT];
  assign ent_slot  = ent[SLOT_W-1:0];
  assign ent_hwy   = ent[HWY_LSB +: HWY_W];

  // Low latency may use the current frame only for slots already written.
  assign rd_bank = (ent_fi || !(ent_slot < slot_cnt)) ? bank_prev(wr_bank) : wr_bank;

  tsi_data_store #(.NUM_HWY(NUM_HWY), .NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W)) u_ds (
    .clk(clk), .wr_bank(wr_bank), .wr_slot(slot_cnt), .wr_data(in_data),
    .rd_bank(rd_bank), .rd_slot(ent_slot), .rd_data(rd_data)
  );

  logic              s1_valid, s1_test;
  logic [HWY_W-1:0]  s1_hwy;
  logic [TBL_W-1:0]  s1_tbl;
  logic [DATA_W-1:0] sel_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_hwy   <= '0;
      s1_tbl   <= '0;
      s1_test  <= 1'b0;
    end else begin
      s1_valid <= ent_valid;
      s1_hwy   <= ent_hwy;
      s1_tbl   <= ent[TBL_LSB +: TBL_W];
      s1_test  <= ent[TST_BIT];
    end
  end

  assign sel_byte = rd_data[s1_hwy*DATA_W +: DATA_W];

  always_ff @(posedge clk) begin
    if (rst || !s1_valid) begin
      out_data <= '1;
      out_tbl  <= '0;
      out_test <= 1'b0;
    end else begin
      out_data <= sel_byte;
      out_tbl  <= s1_tbl;
      out_test <= s1_test;
    end
  end

  AST_IDLE_BYTE: assert property (@(posedge clk) disable iff (rst)
    !s1_valid |=> (out_data == '1 && out_tbl == '0 && !out_test)); // R5
  AST_NO_RAW_COLLIDE: assert property (@(posedge clk) disable iff (rst)
    (ent_valid && ent_slot >= slot_cnt) |-> rd_bank != wr_bank); // R3
  AST_FI_OLD_BANK: assert property (@(posedge clk) disable iff (rst)
    (ent_valid && ent_fi) |-> rd_bank != wr_bank); // R4
endmodule

// File: tb/tsi_switch_core_bench.sv
module tsi_switch_core_bench;
  localparam int NH = 4;
  localparam int NS = 8;
  localparam int SLOT_W = 3;
  localparam int ENT_W = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fsync = 1'b0;
  logic [NH*8-1:0] in_data = '0;
  logic host_we = 1'b0;
  logic [SLOT_W-1:0] host_addr = '0;
  logic [ENT_W-1:0] host_wdata = '0;
  logic [ENT_W-1:0] host_rdata;
  logic [7:0] out_data;
  logic [3:0] out_tbl;
  logic out_test;

  always #5 clk = ~clk;

  tsi_switch_core #(.NUM_HWY(NH), .NUM_SLOTS(NS), .DATA_W(8)) u_tsi_switch_core (
    .clk(clk), .rst(rst), .fsync(fsync), .in_data(in_data),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .out_data(out_data), .out_tbl(out_tbl), .out_test(out_test)
  );

  int n_chk = 0;
  int n_fail = 0;

  // Entry layout (R7), MSB first: valid, fi, test, tbl[3:0], hwy[1:0], slot[2:0]
  function automatic logic [ENT_W-1:0] mk(bit v, bit fi, bit tst, int tb, int h, int s);
    return {v, fi, tst, 4'(tb), 2'(h), 3'(s)};
  endfunction

  localparam logic [ENT_W-1:0] CONN_VEC [NS] = '{
    {1'b1, 1'b0, 1'b0, 4'd3,  2'd1, 3'd5},  // o0 low latency, s>o
    {1'b1, 1'b1, 1'b1, 4'd0,  2'd2, 3'd0},  // o1 frame integrity, test
    {1'b0, 1'b0, 1'b0, 4'd0,  2'd0, 3'd0},  // o2 unconnected
    {1'b1, 1'b0, 1'b0, 4'd9,  2'd0, 3'd2},  // o3 low latency, s<o
    {1'b1, 1'b1, 1'b0, 4'd15, 2'd3, 3'd7},  // o4 frame integrity
    {1'b1, 1'b0, 1'b0, 4'd0,  2'd3, 3'd5},  // o5 low latency, s==o
    {1'b1, 1'b0, 1'b0, 4'd6,  2'd2, 3'd5},  // o6 low latency, s==o-1
    {1'b1, 1'b1, 1'b1, 4'd1,  2'd1, 3'd6}   // o7 frame integrity, test
  };

  // reference model
  logic [7:0] m_ds [3][NH][NS];
  bit m_known [3][NH][NS];
  logic [ENT_W-1:0] m_shadow [NS];
  logic [ENT_W-1:0] m_active [NS];
  int m_slot, m_wb, cyc;
  logic [7:0] p_d [2];
  logic [3:0] p_t [2];
  bit p_x [2];
  bit p_k [2];
  string p_tag [2];
  logic [ENT_W-1:0] rd_exp;

  task automatic chk(string tag, bit ok, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(string sect, bit fs, bit we, int addr, logic [ENT_W-1:0] wd);
    logic [ENT_W-1:0] e;
    int bk;
    // outputs for the slot issued two cycles earlier (R2)
    if (p_k[1]) begin
      n_chk++;
      if (out_data !== p_d[1] || out_tbl !== p_t[1] || out_test !== p_x[1]) begin
        n_fail++;
        $display("FAIL %s %s: actual %h tbl %h test %b expected %h tbl %h test %b",
                 sect, p_tag[1], out_data, out_tbl, out_test, p_d[1], p_t[1], p_x[1]);
      end
    end
    chk("R7 host read-back", host_rdata === rd_exp, 32'(host_rdata), 32'(rd_exp));
    p_d[1] = p_d[0]; p_t[1] = p_t[0]; p_x[1] = p_x[0]; p_k[1] = p_k[0]; p_tag[1] = p_tag[0];
    e = m_active[m_slot];
    if (!e[ENT_W-1]) begin
      p_d[0] = 8'hFF; p_t[0] = 4'h0; p_x[0] = 1'b0; p_k[0] = 1'b1; p_tag[0] = "R5";
    end else begin
      if (e[ENT_W-2]) bk = (m_wb + 2) % 3;
      else bk = (int'(e[2:0]) < m_slot) ? m_wb : (m_wb + 2) % 3;
      p_d[0] = m_ds[bk][e[4:3]][e[2:0]];
      p_k[0] = m_known[bk][e[4:3]][e[2:0]];
      p_t[0] = e[8:5]; p_x[0] = e[9];
      p_tag[0] = e[ENT_W-2] ? "R4/R6" : "R3/R6";
    end
    fsync = fs;
    host_we = we;
    host_addr = SLOT_W'(addr);
    host_wdata = wd;
    for (int h = 0; h < NH; h++) in_data[h*8 +: 8] = 8'(cyc * 4 + h);
    rd_exp = m_shadow[addr];
    @(posedge clk);
    for (int h = 0; h < NH; h++) begin
      m_ds[m_wb][h][m_slot] = 8'(cyc * 4 + h);
      m_known[m_wb][h][m_slot] = 1'b1;
    end
    if (we) m_shadow[addr] = wd;
    if (fs || m_slot == NS - 1) begin
      for (int i = 0; i < NS; i++) m_active[i] = m_shadow[i];
      m_slot = 0;
      m_wb = (m_wb + 1) % 3;
    end else begin
      m_slot++;
    end
    cyc++;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int b = 0; b < 3; b++)
      for (int h = 0; h < NH; h++)
        for (int s = 0; s < NS; s++) begin m_ds[b][h][s] = '0; m_known[b][h][s] = 1'b0; end
    for (int i = 0; i < NS; i++) begin m_shadow[i] = '0; m_active[i] = '0; end
    m_slot = 0; m_wb = 0; cyc = 0; rd_exp = '0;
    for (int i = 0; i < 2; i++) begin
      p_d[i] = 8'hFF; p_t[i] = 4'h0; p_x[i] = 1'b0; p_k[i] = 1'b1; p_tag[i] = "R1";
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 out_data idle", out_data === 8'hFF, 32'(out_data), 32'hFF);
    chk("R1 out_tbl zero", out_tbl === 4'h0, 32'(out_tbl), 32'h0);
    chk("R1 out_test zero", out_test === 1'b0, 32'(out_test), 32'h0);
    chk("R1 host_rdata zero", host_rdata === '0, 32'(host_rdata), 32'h0);
    rst = 1'b0;
    // frame 0: program all entries, last one in the final slot (R8)
    for (int i = 0; i < NS; i++) tick("R8", 1'b0, 1'b1, i, CONN_VEC[i]);
    // main function over several frames (R2)
    for (int i = 0; i < 3 * NS; i++) tick("R2", 1'b0, 1'b0, i % NS, '0);
    // mid-frame rewrite of output slot 5 takes effect next frame (R8)
    for (int i = 0; i < NS; i++) tick("R8", 1'b0, i == 3, (i == 3) ? 5 : i, mk(1, 1, 0, 12, 0, 1));
    for (int i = 0; i < NS; i++) tick("R8", 1'b0, 1'b0, i, '0);
    // early sync in slot 3 leaves stale bytes in that bank (R9)
    for (int i = 0; i < 4; i++) tick("R9", i == 3, 1'b0, i, '0);
    for (int i = 0; i < 4 * NS; i++) tick("R9", 1'b0, 1'b0, i % NS, '0);
    // disconnect output slot 0 (R5)
    for (int i = 0; i < NS; i++) tick("R5", 1'b0, i == 0, 0, mk(0, 0, 1, 7, 2, 2));
    for (int i = 0; i < 2 * NS; i++) tick("R5", 1'b0, 1'b0, i % NS, '0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule